// File: doc/BRIEF.md
# Bitslip Word-Aligning Deserializer

This block turns a single serial bit stream, sampled on a fast bit clock, into parallel words of `FACTOR` bits. A free-running word timer raises a load-enable strobe on the last bit of every word. That strobe acts as the core-clock enable: the finished word, its valid flag and all control state change only on the fast-clock edge where the strobe is high.

Word boundaries can be moved at run time with a slip request. Each accepted request makes the stream read one more fast-clock cycle late, so the word boundary moves by one bit. After a slip the block hides the next words behind its valid flag. It then refuses further requests until the alignment has had time to settle. The slip count runs from 0 to `FACTOR-1` and then wraps. A status flag reports each wrap, a fixed number of core cycles after the slip that caused it.

Top module: `bitslip_deser`

## Requirements
- R1: Each word holds `FACTOR` consecutive serial bits. The bit sampled first appears in `wordOut[FACTOR-1]` and the bit sampled last appears in `wordOut[0]`.
- R2: `loadEn` is high for one fast cycle in every `FACTOR` cycles. `wordOut`, `wordValid` and `slipMax` change only on the rising edge that ends a cycle in which `loadEn` is high.
- R3: A synchronous active-high `rst` clears the word timer, the delay line, the slip count and all flags. While reset is held, `wordOut` is 0, `wordValid` is 0 and `slipMax` is 0. The fast edge after reset is released is bit 0 of the first word.
- R4: The first word completed after reset is reported with `wordValid` high.
- R5: With k accepted slips (k counted modulo `FACTOR`), the bit sampled at fast edge n is the serial input from edge n-k. Edges before the first edge after reset read as 0. A slip changes the alignment starting with the word after the core edge that accepts it.
- R6: `slipReq` is sampled only on core edges and is edge-detected. A request is a sample of 1 where the previous core sample was 0, so a level held high over many words is counted once.
- R7: For 5 core edges after an accepted slip, new requests are ignored and leave the alignment unchanged.
- R8: The two words completed on the two core edges after an accepted slip have `wordValid` low. Later words are valid again.
- R9: After `FACTOR` accepted slips the slip count wraps to 0, and the alignment is the same as with no slip.
- R10: When a slip moves the count from `FACTOR-1` to 0, `slipMax` goes high on the fifth core edge after that slip and stays high for one core cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bit clock |
| rst | input | 1 | Synchronous active-high reset |
| serIn | input | 1 | Serial data, one bit per fast cycle |
| slipReq | input | 1 | Slip request, sampled on core edges |
| loadEn | output | 1 | Core-clock enable, high in the last bit cycle of each word |
| wordOut | output | FACTOR | Parallel word, first-received bit in the MSB |
| wordValid | output | 1 | High when `wordOut` holds trusted data |
| slipMax | output | 1 | One core cycle pulse reporting a slip-count wrap |

## Verification
The hardest case to reach from the ports is the wrap flag. It needs `FACTOR` accepted slips, and every request has to arrive as a fresh edge outside the settle window of the previous one. The stimulus sends one slip request per word-sized burst, spaced seven words apart. Along the way it mixes in a request held high for many words and a second request that lands inside the settle window. The scoreboard tracks how many slips should have been accepted. For every word it predicts the realigned data, the valid flag and the wrap pulse, so a skipped or extra acceptance appears as misaligned words several requests later.

// File: rtl/bsd_pkg.sv
package bsd_pkg;

  // Strobes from the control section to the datapath, one set per fast cycle.
  typedef struct packed {
    logic load;      // capture the completed word this cycle
    logic wordGood;  // the word captured this cycle may be trusted
  } bsd_strobe_t;

endpackage

// File: rtl/bsd_word_timer.sv
module bsd_word_timer #(
  parameter int FACTOR = 8
) (
  input  logic clk,
  input  logic rst,
  output logic loadEn
);
  localparam int PW = $clog2(FACTOR);
  localparam logic [PW-1:0] LAST = PW'(FACTOR - 1);

  logic [PW-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
    end else if (phase == LAST) begin
      phase <= '0;
    end else begin
      phase <= phase + 1'b1;
    end
  end

  assign loadEn = (phase == LAST);

  // R2: phase never leaves its range
  a_r2_phase_range: assert property (@(posedge clk) disable iff (rst)
    phase <= LAST);

  // R2: the core enable is a single-cycle strobe
  a_r2_strobe_single: assert property (@(posedge clk) disable iff (rst)
    loadEn |=> !loadEn);

endmodule

// File: rtl/bsd_slip_ctrl.sv
module bsd_slip_ctrl
  import bsd_pkg::*;
#(
  parameter int FACTOR       = 8,
  parameter int SETTLE_WORDS = 5,
  parameter int PURGE_WORDS  = 2,
  parameter int FLAG_DELAY   = 5
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        loadEn,
  input  logic                        slipReq,
  output bsd_strobe_t                 stb,
  output logic [$clog2(FACTOR)-1:0]   tapSel,
  output logic                        slipMax
);
  localparam int TW = $clog2(FACTOR);
  localparam int SW = $clog2(SETTLE_WORDS + 1);
  localparam int QW = $clog2(PURGE_WORDS + 1);
  localparam int MW = $clog2(FLAG_DELAY + 1);
  localparam logic [TW-1:0] TOP = TW'(FACTOR - 1);

  logic          slipPrev;
  logic [TW-1:0] tapCnt;
  logic [SW-1:0] settleCnt;
  logic [QW-1:0] purgeCnt;
  logic [MW-1:0] flagCnt;
  logic          maxFlag;
  logic          acceptNow;
  logic          wrapNow;

  assign acceptNow = loadEn && slipReq && !slipPrev && (settleCnt == '0);
  assign wrapNow   = acceptNow && (tapCnt == TOP);

  // Slip counter and request edge detector, core-enable domain
  always_ff @(posedge clk) begin
    if (rst) begin
      slipPrev <= 1'b0;
      tapCnt   <= '0;
    end else if (loadEn) begin
      slipPrev <= slipReq;
      if (acceptNow) begin
        tapCnt <= (tapCnt == TOP) ? '0 : tapCnt + 1'b1;
      end
    end
  end

  // Settle window and purge window
  always_ff @(posedge clk) begin
    if (rst) begin
      settleCnt <= '0;
      purgeCnt  <= '0;
    end else if (loadEn) begin
      if (acceptNow) begin
        settleCnt <= SW'(SETTLE_WORDS);
        purgeCnt  <= QW'(PURGE_WORDS);
      end else begin
        if (settleCnt != '0) settleCnt <= settleCnt - 1'b1;
        if (purgeCnt != '0)  purgeCnt  <= purgeCnt - 1'b1;
      end
    end
  end

  // Delayed wrap flag
  always_ff @(posedge clk) begin
    if (rst) begin
      flagCnt <= '0;
      maxFlag <= 1'b0;
    end else if (loadEn) begin
      maxFlag <= (flagCnt == MW'(1));
      if (wrapNow) begin
        flagCnt <= MW'(FLAG_DELAY);
      end else if (flagCnt != '0) begin
        flagCnt <= flagCnt - 1'b1;
      end
    end
  end

  assign stb.load     = loadEn;
  assign stb.wordGood = (purgeCnt == '0);
  assign tapSel       = tapCnt;
  assign slipMax      = maxFlag;

  // R9: the slip count steps by one or wraps from the top to zero
  a_r9_tap_step: assert property (@(posedge clk) disable iff (rst)
    (tapCnt != $past(tapCnt)) |->
      (($past(tapCnt) == TOP) ? (tapCnt == '0) : (tapCnt == TW'($past(tapCnt) + 1'b1))));

  // R7: a core edge inside the settle window leaves alignment alone
  a_r7_settle_hold: assert property (@(posedge clk) disable iff (rst)
    (loadEn && settleCnt != '0) |=> $stable(tapCnt));

  // R6: a request level already seen on the previous core edge is not counted
  a_r6_edge_only: assert property (@(posedge clk) disable iff (rst)
    (loadEn && slipPrev) |=> $stable(tapCnt));

  // R8: the word after an accepted slip is marked untrusted
  a_r8_purge_start: assert property (@(posedge clk) disable iff (rst)
    acceptNow |=> !stb.wordGood);

  // R10: the wrap flag moves only on core edges and lasts one core cycle
  a_r10_flag_on_core: assert property (@(posedge clk) disable iff (rst)
    !$past(loadEn) |-> $stable(slipMax));
  a_r10_flag_single: assert property (@(posedge clk) disable iff (rst)
    (loadEn && slipMax) |=> !slipMax);

endmodule

// File: rtl/bsd_datapath.sv
module bsd_datapath
  import bsd_pkg::*;
#(
  parameter int FACTOR = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       serIn,
  input  bsd_strobe_t                stb,
  input  logic [$clog2(FACTOR)-1:0]  tapSel,
  output logic [FACTOR-1:0]          wordOut,
  output logic                       wordValid
);
  localparam int TW    = $clog2(FACTOR);
  localparam int DEPTH = FACTOR - 1;

  logic [DEPTH-1:0]  delayLine;
  logic [FACTOR-1:0] shiftReg;
  logic              tapBit;
  logic [FACTOR-1:0] nextWord;

  // Delay line: delayLine[i] holds the serial bit from i+1 cycles ago
  always_ff @(posedge clk) begin
    if (rst) begin
      delayLine <= '0;
    end else begin
      delayLine <= {delayLine[DEPTH-2:0], serIn};
    end
  end

  // Tap multiplexer: tap 0 is the live input
  always_comb begin
    tapBit = serIn;
    for (int i = 0; i < DEPTH; i++) begin
      if (tapSel == TW'(i + 1)) tapBit = delayLine[i];
    end
  end

  assign nextWord = {shiftReg[FACTOR-2:0], tapBit};

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg <= '0;
    end else begin
      shiftReg <= nextWord;
    end
  end

  // Output word register, written once per core cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      wordOut   <= '0;
      wordValid <= 1'b0;
    end else if (stb.load) begin
      wordOut   <= nextWord;
      wordValid <= stb.wordGood;
    end
  end

  // R2: the word holds between core edges
  a_r2_word_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(stb.load) |-> ($stable(wordOut) && $stable(wordValid)));

endmodule

// File: rtl/bitslip_deser.sv
module bitslip_deser
  import bsd_pkg::*;
#(
  parameter int FACTOR       = 8,
  parameter int SETTLE_WORDS = 5,
  parameter int PURGE_WORDS  = 2,
  parameter int FLAG_DELAY   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              serIn,
  input  logic              slipReq,
  output logic              loadEn,
  output logic [FACTOR-1:0] wordOut,
  output logic              wordValid,
  output logic              slipMax
);
  localparam int TW = $clog2(FACTOR);

  generate
    if (FACTOR < 3 || FACTOR > 10) begin : g_bad_factor
      $error("FACTOR must lie between 3 and 10");
    end
  endgenerate

  bsd_strobe_t   stb;
  logic [TW-1:0] tapSel;

  bsd_word_timer #(.FACTOR(FACTOR)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .loadEn (loadEn)
  );

  bsd_slip_ctrl #(
    .FACTOR       (FACTOR),
    .SETTLE_WORDS (SETTLE_WORDS),
    .PURGE_WORDS  (PURGE_WORDS),
    .FLAG_DELAY   (FLAG_DELAY)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .loadEn  (loadEn),
    .slipReq (slipReq),
    .stb     (stb),
    .tapSel  (tapSel),
    .slipMax (slipMax)
  );

  bsd_datapath #(.FACTOR(FACTOR)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .serIn     (serIn),
    .stb       (stb),
    .tapSel    (tapSel),
    .wordOut   (wordOut),
    .wordValid (wordValid)
  );

endmodule

// File: tb/bitslip_deser_test.sv
`timescale 1ns/1ps
module bitslip_deser_test;
  localparam int F = 8;

  logic         clk = 1'b0;
  logic         rst;
  logic         serIn;
  logic         slipReq;
  logic         loadEn;
  logic [F-1:0] wordOut;
  logic         wordValid;
  logic         slipMax;

  always #2.5 clk = ~clk;

  bitslip_deser #(.FACTOR(F)) uut (
    .clk       (clk),
    .rst       (rst),
    .serIn     (serIn),
    .slipReq   (slipReq),
    .loadEn    (loadEn),
    .wordOut   (wordOut),
    .wordValid (wordValid),
    .slipMax   (slipMax)
  );

  typedef struct {
    logic [F-1:0] word;
    bit           valid;
    bit           maxF;
    string        tag;
  } exp_t;

  exp_t q[$];
  logic hist[$];
  int   checks = 0;
  int   errors = 0;
  int   wordNo = 0;
  bit   done   = 0;

  // Bench model of the slip control, built from the requirements
  int   kSlip  = 0;
  int   settle = 0;
  int   purge  = 0;
  int   flagD  = 0;
  bit   prevSlip = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [F-1:0] pat(input int n);
    return F'((n * 45 + 23) ^ (n * n * 7) ^ (n << 3));
  endfunction

  task automatic sendWord(input logic [F-1:0] data, input bit slip, input string tag);
    int base;
    base = hist.size();
    slipReq = slip;
    for (int i = 0; i < F; i++) begin
      serIn = data[F-1-i];
      hist.push_back(data[F-1-i]);
      if (i == F - 1) begin
        exp_t e;
        bit   accept;
        for (int b = 0; b < F; b++) begin
          int idx;
          idx = base + b - kSlip;
          e.word[F-1-b] = (idx >= 0) ? hist[idx] : 1'b0;
        end
        e.valid = (purge == 0);
        e.maxF  = (flagD == 1);
        e.tag   = tag;
        accept  = slip && !prevSlip && (settle == 0);
        if (accept) begin
          settle = 5;
          purge  = 2;
          if (kSlip == F - 1) flagD = 5;
          else if (flagD != 0) flagD--;
          kSlip = (kSlip + 1) % F;
        end else begin
          if (settle != 0) settle--;
          if (purge != 0)  purge--;
          if (flagD != 0)  flagD--;
        end
        prevSlip = slip;
        q.push_back(e);
      end
      @(negedge clk);
    end
    wordNo++;
  endtask

  task automatic idle(input int n, input string tag);
    for (int j = 0; j < n; j++) sendWord(pat(wordNo), 1'b0, tag);
  endtask

  // Monitor: samples on the falling edge after each core edge
  logic prevLoad = 1'b0;
  int   gap = 0;
  int   loads = 0;
  always @(posedge clk) prevLoad <= loadEn;

  always @(negedge clk) begin
    if (!rst) gap++;
    if (!rst && prevLoad) begin
      exp_t e;
      if (loads > 0) check(gap == F, "R2", "load spacing", gap, F);
      gap = 0;
      loads++;
      if (q.size() == 0) begin
        check(1'b0, "R2", "unexpected word", wordOut, 0);
      end else begin
        e = q.pop_front();
        check(wordValid == e.valid, (e.tag == "R4") ? "R4" : "R8",
              "valid flag", wordValid, e.valid);
        if (e.valid) check(wordOut == e.word, e.tag, "word", wordOut, e.word);
        check(slipMax == e.maxF, "R10", "wrap flag", slipMax, e.maxF);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "R2", "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1'b1;
    serIn = 1'b0;
    slipReq = 1'b0;
    repeat (4) @(negedge clk);
    // R3: reset state
    check(wordOut == '0, "R3", "word in reset", wordOut, 0);
    check(wordValid == 1'b0, "R3", "valid in reset", wordValid, 0);
    check(slipMax == 1'b0, "R3", "flag in reset", slipMax, 0);
    check(loadEn == 1'b0, "R3", "strobe in reset", loadEn, 0);
    rst = 1'b0;

    // R4, R1: first word and plain words, including a fixed MSB-first pattern
    sendWord(pat(wordNo), 1'b0, "R4");
    sendWord(F'(8'b1000_0001), 1'b0, "R1");
    sendWord(F'(8'b0111_0010), 1'b0, "R1");
    idle(2, "R1");

    // R5: two isolated slips
    for (int s = 0; s < 2; s++) begin
      sendWord(pat(wordNo), 1'b1, "R5");
      idle(6, "R5");
    end

    // R6: level held high for many words counts once
    for (int s = 0; s < 9; s++) sendWord(pat(wordNo), 1'b1, "R6");
    idle(4, "R6");

    // R7: a second request inside the settle window is ignored
    sendWord(pat(wordNo), 1'b1, "R7");
    sendWord(pat(wordNo), 1'b0, "R7");
    sendWord(pat(wordNo), 1'b1, "R7");
    idle(7, "R7");

    // R9: four more slips reach the wrap point, back to zero offset
    for (int s = 0; s < F - 4; s++) begin
      sendWord(pat(wordNo), 1'b1, "R9");
      idle(6, "R9");
    end
    idle(3, "R9");

    // R5: alignment after wrap, one more slip
    sendWord(pat(wordNo), 1'b1, "R5");
    idle(6, "R5");

    repeat (3) @(negedge clk);
    check(q.size() == 0, "R2", "words left over", q.size(), 0);
    check(kSlip == 1, "R9", "bench slip count", kSlip, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule